// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block decides when a fast page mode DRAM controller must run refresh cycles. After reset it keeps the memory closed for a power-up pause of at least 200 microseconds. It then asks for a fixed run of back-to-back refresh cycles, eight by default. Only when the controller has accepted all of them does it declare the memory ready. From then on it raises one refresh request per refresh interval. The interval comes from the clock frequency, the row count and the retention period. A mode input picks the long period that low-power parts allow.

Refreshes are of the CAS-before-RAS kind, so the DRAM's own row counter picks the row. The scheduler therefore issues requests only and carries no row address. The controller may be busy with a page burst when an interval expires. Each expiry is therefore added to a pending count, and each accepted refresh takes one away, so late refreshes are still owed and are not forgotten. The pending count saturates. A sticky flag shows that an interval was dropped because the count was already full.

The controller treats `refresh_req` as a level. It pulses `refresh_ack` for one cycle for each refresh cycle it starts. An acknowledge counts only in a cycle where the request is high.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `refresh_req`, `init_done` and `refresh_overflow` are all 0. A later reset returns the block to this state.
- R2: After reset is released, `refresh_req` and `init_done` stay low for exactly PAUSE = ceil(CLK_HZ * PAUSE_US / 10^6) rising edges. `refresh_ack` is ignored during this pause.
- R3: When the pause ends, `refresh_req` goes high and stays high without a gap until INIT_REFRESHES acknowledges have been taken. `init_done` stays 0 until then.
- R4: `init_done` rises on the edge that takes the last start-up acknowledge. It then stays 1 until reset, and `refresh_req` is 0 in the following cycle.
- R5: With `lp_mode` = 0, one refresh interval is floor(CLK_HZ * PERIOD_NORM_MS / (1000 * ROWS)) cycles. The first interval expires that many edges after the edge that raised `init_done`.
- R6: With `lp_mode` = 1, one interval is floor(CLK_HZ * PERIOD_LP_MS / (1000 * ROWS)) cycles.
- R7: Each expired interval adds one to the pending count and each taken acknowledge removes one. When both fall in the same cycle the count is unchanged. After initialisation, `refresh_req` is high exactly when the count is non-zero.
- R8: The pending count saturates at DEBT_MAX. An interval that expires with the count at DEBT_MAX and no acknowledge is dropped and sets `refresh_overflow`, which stays 1 until reset.
- R9: An acknowledge while `refresh_req` is 0 has no effect on the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 1 | 1 selects the long (low-power) refresh period |
| refresh_ack | input | 1 | Controller accepted one refresh cycle this cycle |
| refresh_req | output | 1 | A refresh cycle is wanted |
| init_done | output | 1 | Power-up sequence finished; normal accesses allowed |
| refresh_overflow | output | 1 | Sticky: an interval was dropped at a full pending count |

## Verification
Two functions can act in the same cycle: an interval expiry that raises the pending count, and a taken acknowledge that lowers it. The bench provokes this in two ways. It aims a single acknowledge at the edge where a known interval ends while one refresh is already owed. It also drives pseudo-random acknowledge densities in both period modes. The result is judged by how many further acknowledges are needed before `refresh_req` falls. The same counting shows the saturation case, where a full count plus an expiry with no acknowledge must leave exactly DEBT_MAX refreshes owed and raise the overflow flag.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_INIT  = 2'd1,
        PH_RUN   = 2'd2
    } rfsh_phase_e;

    typedef struct packed {
        logic owed;
        logic dropped;
    } debt_flags_t;

    function automatic int unsigned cyc_ceil(longint unsigned num, longint unsigned den);
        longint unsigned q;
        q = (num + den - 64'd1) / den;
        return q[31:0];
    endfunction

    function automatic int unsigned cyc_floor(longint unsigned num, longint unsigned den);
        longint unsigned q;
        q = num / den;
        return q[31:0];
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_init_seq.sv
module rfsh_init_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC      = 20000,
    parameter int unsigned INIT_REFRESHES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        refresh_ack,
    output rfsh_phase_e phase
);
    localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
    localparam int unsigned IW = $clog2(INIT_REFRESHES + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [IW-1:0] I_LAST = IW'(INIT_REFRESHES - 1);

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pause_cnt <= '0;
            init_cnt  <= '0;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == P_LAST) phase <= PH_INIT;
                    else                     pause_cnt <= pause_cnt + PW'(1);
                end
                PH_INIT: begin
                    if (refresh_ack) begin
                        if (init_cnt == I_LAST) phase <= PH_RUN;
                        else                    init_cnt <= init_cnt + IW'(1);
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAUSE && pause_cnt != P_LAST) |=> phase == PH_PAUSE); // R2
    AST_INIT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INIT && refresh_ack && init_cnt == I_LAST) |=> phase == PH_RUN); // R4
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        phase == PH_RUN |=> phase == PH_RUN); // R4

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned NORM_CYC = 1562,
    parameter int unsigned LP_CYC   = 12500,
    parameter int unsigned TW       = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lp_mode,
    output logic tick
);
    localparam logic [TW-1:0] LAST_N = TW'(NORM_CYC - 1);
    localparam logic [TW-1:0] LAST_L = TW'(LP_CYC - 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] last;

    generate
        if (NORM_CYC == LP_CYC) begin : g_single
            logic unused_mode;
            assign unused_mode = lp_mode;
            assign last = LAST_N;
        end else begin : g_dual
            assign last = lp_mode ? LAST_L : LAST_N;
        end
    endgenerate

    // >= so that a switch to the shorter period ends an overlong count at once
    assign tick = en && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + TW'(1);
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == '0); // R5
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0 && !tick)); // R6

endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc,
    input  logic        dec,
    output debt_flags_t flags
);
    localparam int unsigned DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] D_FULL = DW'(DEBT_MAX);

    logic [DW-1:0] debt;
    logic          lost;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
            lost <= 1'b0;
        end else begin
            if (inc && !dec) begin
                if (debt == D_FULL) lost <= 1'b1;
                else                debt <= debt + DW'(1);
            end else if (dec && !inc && debt != '0) begin
                debt <= debt - DW'(1);
            end
        end
    end

    assign flags.owed    = (debt != '0);
    assign flags.dropped = lost;

    AST_DEBT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && debt != '0) |=> debt == $past(debt) - DW'(1)); // R7
    AST_DEBT_BOTH: assert property (@(posedge clk) disable iff (rst)
        (dec && inc) |=> $stable(debt)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (debt == D_FULL && inc && !dec) |=> (debt == D_FULL && lost)); // R8
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        lost |=> lost); // R8

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 100_000_000,
    parameter int unsigned PAUSE_US       = 200,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned ROWS           = 1024,
    parameter int unsigned PERIOD_NORM_MS = 16,
    parameter int unsigned PERIOD_LP_MS   = 128,
    parameter int unsigned DEBT_MAX       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_mode,
    input  logic refresh_ack,
    output logic refresh_req,
    output logic init_done,
    output logic refresh_overflow
);
    localparam int unsigned PAUSE_CYC =
        cyc_ceil(64'(CLK_HZ) * 64'(PAUSE_US), 64'd1_000_000);
    localparam int unsigned NORM_CYC =
        cyc_floor(64'(CLK_HZ) * 64'(PERIOD_NORM_MS), 64'd1000 * 64'(ROWS));
    localparam int unsigned LP_CYC =
        cyc_floor(64'(CLK_HZ) * 64'(PERIOD_LP_MS), 64'd1000 * 64'(ROWS));
    localparam int unsigned TW = $clog2(umax(NORM_CYC, LP_CYC) + 1);

    rfsh_phase_e phase;
    logic        tick;
    logic        take;
    debt_flags_t dflags;

    rfsh_init_seq #(
        .PAUSE_CYC      (PAUSE_CYC),
        .INIT_REFRESHES (INIT_REFRESHES)
    ) u_init (
        .clk         (clk),
        .rst         (rst),
        .refresh_ack (refresh_ack),
        .phase       (phase)
    );

    rfsh_interval_timer #(
        .NORM_CYC (NORM_CYC),
        .LP_CYC   (LP_CYC),
        .TW       (TW)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (phase == PH_RUN),
        .lp_mode (lp_mode),
        .tick    (tick)
    );

    assign take = refresh_ack && refresh_req && (phase == PH_RUN);

    rfsh_debt_ctr #(
        .DEBT_MAX (DEBT_MAX)
    ) u_debt (
        .clk   (clk),
        .rst   (rst),
        .inc   (tick),
        .dec   (take),
        .flags (dflags)
    );

    always_comb begin
        case (phase)
            PH_INIT: refresh_req = 1'b1;
            PH_RUN:  refresh_req = dflags.owed;
            default: refresh_req = 1'b0;
        endcase
    end

    assign init_done        = (phase == PH_RUN);
    assign refresh_overflow = dflags.dropped;

    AST_INIT_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INIT && !init_done) |=> (refresh_req || init_done)); // R3
    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (init_done && !refresh_req && refresh_ack && !tick) |=> !refresh_req); // R9
    AST_TICK_RAISES: assert property (@(posedge clk) disable iff (rst)
        (tick && !take) |=> refresh_req); // R7

endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int P  = 200;   // ceil(1e6*200/1e6)
    localparam int NI = 15;    // floor(1e6*16/(1000*1024))
    localparam int NL = 125;   // floor(1e6*128/(1000*1024))
    localparam int DM = 8;
    localparam int IR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp = 1'b0;
    logic ack = 1'b0;
    logic req, done, ovf;

    int errs = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dram_refresh_sched #(.CLK_HZ(CLK_HZ)) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .lp_mode(lp), .refresh_ack(ack),
        .refresh_req(req), .init_done(done), .refresh_overflow(ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // requirement-level cycle model: 0 pause, 1 start-up, 2 running
    int m_ph, m_pc, m_ic, m_t, m_debt;
    bit m_ovf;
    always @(posedge clk) begin
        int lim;
        bit tk, tkn;
        if (rst) begin
            m_ph <= 0; m_pc <= 0; m_ic <= 0; m_t <= 0; m_debt <= 0; m_ovf <= 1'b0;
        end else begin
            case (m_ph)
                0: if (m_pc == P - 1) m_ph <= 1; else m_pc <= m_pc + 1;
                1: if (ack) begin
                       if (m_ic == IR - 1) m_ph <= 2; else m_ic <= m_ic + 1;
                   end
                default: begin
                    lim = lp ? NL : NI;
                    tk = (m_t >= lim - 1);
                    m_t <= tk ? 0 : m_t + 1;
                    tkn = ack && (m_debt > 0);
                    if (tk && !tkn) begin
                        if (m_debt == DM) m_ovf <= 1'b1; else m_debt <= m_debt + 1;
                    end else if (!tk && tkn) m_debt <= m_debt - 1;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R7 req vs pending model", int'(req), int'(m_ph == 1 || (m_ph == 2 && m_debt > 0)));
            chk("R4 init_done vs model", int'(done), int'(m_ph == 2));
            chk("R8 overflow vs model", int'(ovf), int'(m_ovf));
        end
    end

    task automatic wait_req(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!req && n < 5000);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        int n;
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", int'(req), 0);
        chk("R1 init_done in reset", int'(done), 0);
        chk("R1 overflow in reset", int'(ovf), 0);
        rst = 1'b0;
        ack = 1'b1;           // R2: ignored throughout the pause
        cmp_en = 1'b1;
        @(negedge clk);
        chk("R1 req first cycle", int'(req), 0);
        n = 1;
        while (!req && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ack = 1'b0;
        chk("R2 pause length", n, P);
        chk("R2 init_done after pause", int'(done), 0);

        // R3: start-up refreshes with gaps between acknowledges
        for (int i = 0; i < IR; i++) begin
            pulse_ack();
            if (i < IR - 1) begin
                repeat (i % 3) @(negedge clk);
                chk("R3 req held during start-up", int'(req), 1);
                chk("R3 init_done low during start-up", int'(done), 0);
            end
        end
        chk("R4 init_done after last start-up ack", int'(done), 1);
        chk("R4 req low after start-up", int'(req), 0);

        wait_req(n);
        chk("R5 first normal interval", n, NI);

        // R7: four owed, three acks keep req, fourth clears
        repeat (3 * NI) @(negedge clk);
        ack = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 req while refreshes owed", int'(req), 1);
        end
        @(negedge clk);
        chk("R7 req cleared after fourth ack", int'(req), 0);
        // R9: acks with req low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 ack with req low keeps req low", int'(req), 0);
        end
        ack = 1'b0;
        wait_req(n);
        chk("R9 next request at interval end", n, NI - 9);
        pulse_ack();
        chk("R9 one ack clears single owed refresh", int'(req), 0);

        // R8: saturation
        wait_req(n);
        repeat (7 * NI) @(negedge clk);
        chk("R8 no overflow at full count", int'(ovf), 0);
        repeat (NI) @(negedge clk);
        chk("R8 overflow after dropped interval", int'(ovf), 1);
        ack = 1'b1;
        for (int i = 0; i < DM - 1; i++) @(negedge clk);
        chk("R8 req after DEBT_MAX-1 acks", int'(req), 1);
        @(negedge clk);
        ack = 1'b0;
        chk("R8 req clear after DEBT_MAX acks", int'(req), 0);
        chk("R8 overflow sticky", int'(ovf), 1);

        // R7: acknowledge on the same edge as an interval expiry
        wait_req(n);
        repeat (NI - 1) @(negedge clk);
        pulse_ack();
        chk("R7 tick and ack together keep one owed", int'(req), 1);
        pulse_ack();
        chk("R7 single ack then clears", int'(req), 0);

        // R6 / R5: spacing with ack held high
        lp = 1'b1;
        ack = 1'b1;
        wait_req(n);
        wait_req(n);
        chk("R6 low-power interval", n, NL);
        wait_req(n);
        chk("R6 low-power interval repeat", n, NL);
        lp = 1'b0;
        wait_req(n);
        wait_req(n);
        chk("R5 normal interval spacing", n, NI);
        ack = 1'b0;

        // pseudo-random acknowledge densities, compared against the model
        lf = 16'hACE1;
        for (int seg = 0; seg < 4; seg++) begin
            lp = (seg == 2);
            for (int c = 0; c < 1500; c++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                case (seg)
                    0: ack = lf[0];
                    1: ack = lf[0] & lf[3] & lf[7] & lf[9];
                    2: ack = lf[2] & lf[5];
                    default: ack = lf[1] | lf[4];
                endcase
                @(negedge clk);
            end
        end
        ack = 1'b0;

        // R1 / R4: reset during operation
        rst = 1'b1;
        @(negedge clk);
        chk("R1 req after mid-run reset", int'(req), 0);
        chk("R4 init_done cleared by reset", int'(done), 0);
        chk("R1 overflow cleared by reset", int'(ovf), 0);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        chk("R2 pause restarts after reset", int'(req), 0);
        chk("R4 init_done low in new pause", int'(done), 0);
        report();
    end
endmodule